// File: doc/BRIEF.md
# Multi-Warp Instruction Fetch Selector

This block sits at the front of a multithreaded SIMT core. Each cycle it picks at most one warp to fetch instructions for and sends one request to the instruction cache. Each warp has a program counter, a finished flag and an instruction-buffer-empty flag, all supplied from outside. The block itself keeps a miss-pending flag for each warp, a pointer to the warp it served last, and a single fetch buffer that a downstream decoder drains.

The search for a candidate begins at the warp after the last one served and wraps around the warp count. For the selected warp, the block forms a byte address by adding a fixed program-memory base to the PC. It also computes a byte count that never runs past the end of the cache line. The cache answers in the same cycle with hit, miss or reservation failure, and each answer moves the pointer. When a miss fill returns later, it is loaded into the fetch buffer. A fill takes priority over any new request.

Top module: `warp_fetch_sel`

## Requirements
- R1: After reset no warp has a miss pending, the fetch buffer is empty and the last-served pointer is warp 0, so the first scan begins at warp 1.
- R2: The scan starts at the warp after the last-served pointer and wraps modulo NUM_WARPS. The first eligible warp found is the one offered.
- R3: A warp is eligible only when its finished flag is clear, it has no miss pending, and its instruction buffer is empty.
- R4: At most one request is offered per cycle, and none is offered while the fetch buffer holds valid contents.
- R5: The request address is the warp PC plus 0xF0000000, modulo 2^32.
- R6: Let the line offset be the PC modulo the line size (64 bytes). The request size is 16 bytes when the offset plus 16 does not exceed 64, and 64 minus the offset otherwise.
- R7: A request accepted with response code 0 (hit) loads the fetch buffer with that warp's PC, byte count and warp id, and moves the pointer to that warp.
- R8: A request accepted with response code 1 (miss) sets that warp's miss-pending flag and moves the pointer, and leaves the fetch buffer empty.
- R9: A request accepted with response code 2 (reservation failure) moves only the pointer. Miss flags and the fetch buffer stay unchanged.
- R10: When the fetch buffer is empty and a fill is presented, the filled warp's miss flag is cleared and the buffer is loaded with that warp's PC, byte count and id. No request is offered in that cycle. `fill_ready` is high exactly when the buffer is empty, and a fill presented while the buffer is full has no effect.
- R11: Asserting `fb_take` while the buffer is valid empties it at the next clock edge. Otherwise valid contents are held unchanged.
- R12: A request offered while `req_ready` is low changes neither the pointer nor any miss flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| warp_done | input | NUM_WARPS | Warp has finished execution |
| ibuf_empty | input | NUM_WARPS | Warp's instruction buffer is empty |
| warp_pc | input | NUM_WARPS*PC_W | Packed per-warp PCs, warp i at bits [i*PC_W +: PC_W] |
| req_valid | output | 1 | Fetch request offered to the cache |
| req_ready | input | 1 | Cache accepts the request this cycle |
| req_addr | output | PC_W | Request byte address |
| req_size | output | SZ_W | Request byte count |
| req_warp | output | WID_W | Requesting warp id |
| rsp_code | input | 2 | Same-cycle response: 0 hit, 1 miss, 2 reservation fail |
| fill_valid | input | 1 | A miss fill is ready |
| fill_warp | input | WID_W | Warp the fill belongs to |
| fill_ready | output | 1 | A fill is taken this cycle if valid |
| fb_valid | output | 1 | Fetch buffer holds contents |
| fb_pc | output | PC_W | Buffered PC |
| fb_size | output | SZ_W | Buffered byte count |
| fb_warp | output | WID_W | Buffered warp id |
| fb_take | input | 1 | Consumer takes the buffer |
| miss_pend | output | NUM_WARPS | Per-warp miss-pending flags |
| last_warp | output | WID_W | Last-served pointer |

## Verification
The bench targets the wrap of the scan from the highest warp back to warp 0. A design that wrapped wrongly, or that restarted the scan at the pointer itself, would offer the warp it had just served. The bench also probes line offsets of 48, 56 and 63. A wrong boundary comparison would show up as 16-byte requests that cross the line, or as short requests at an offset of exactly 48. Reservation failures are checked to move the pointer and nothing else: a design that also set the miss flag would silently park that warp. Fills are presented both while the buffer is full and while requests are eligible. These cases expose a design that drops or double-loads a fill, or lets a request race ahead of the fill.

// File: rtl/warp_fetch_sel.sv
module warp_fetch_sel #(
  parameter int NUM_WARPS = 8,
  parameter int PC_W = 32,
  parameter int LINE_BYTES = 64,
  parameter int FETCH_BYTES = 16,
  parameter logic [PC_W-1:0] PROG_BASE = 32'hF000_0000,
  localparam int WID_W = $clog2(NUM_WARPS),
  localparam int OFF_W = $clog2(LINE_BYTES),
  localparam int SZ_W = $clog2(FETCH_BYTES + 1)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_WARPS-1:0]      warp_done,
  input  logic [NUM_WARPS-1:0]      ibuf_empty,
  input  logic [NUM_WARPS*PC_W-1:0] warp_pc,
  output logic                      req_valid,
  input  logic                      req_ready,
  output logic [PC_W-1:0]           req_addr,
  output logic [SZ_W-1:0]           req_size,
  output logic [WID_W-1:0]          req_warp,
  input  logic [1:0]                rsp_code,
  input  logic                      fill_valid,
  input  logic [WID_W-1:0]          fill_warp,
  output logic                      fill_ready,
  output logic                      fb_valid,
  output logic [PC_W-1:0]           fb_pc,
  output logic [SZ_W-1:0]           fb_size,
  output logic [WID_W-1:0]          fb_warp,
  input  logic                      fb_take,
  output logic [NUM_WARPS-1:0]      miss_pend,
  output logic [WID_W-1:0]          last_warp
);

  localparam logic [1:0] RSP_HIT  = 2'd0;
  localparam logic [1:0] RSP_MISS = 2'd1;

  logic [PC_W-1:0]      pc_arr [NUM_WARPS];
  logic [NUM_WARPS-1:0] elig;
  logic                 found;
  logic [WID_W-1:0]     sel;
  logic                 fill_go, fire;

  for (genvar g = 0; g < NUM_WARPS; g++) begin : g_pc
    assign pc_arr[g] = warp_pc[g*PC_W +: PC_W];
  end

  function automatic logic [SZ_W-1:0] size_of(input logic [PC_W-1:0] pc);
    int off;
    off = int'(pc[OFF_W-1:0]);
    if (off + FETCH_BYTES > LINE_BYTES) return SZ_W'(LINE_BYTES - off);
    return SZ_W'(FETCH_BYTES);
  endfunction

  assign elig = ~warp_done & ~miss_pend & ibuf_empty;

  always_comb begin
    found = 1'b0;
    sel = last_warp;
    for (int k = 1; k <= NUM_WARPS; k++) begin
      int idx;
      idx = (int'(last_warp) + k) % NUM_WARPS;
      if (!found && elig[idx]) begin
        found = 1'b1;
        sel = WID_W'(idx);
      end
    end
  end

  assign fill_ready = !fb_valid;
  assign fill_go    = fill_valid && !fb_valid;
  assign req_valid  = !fb_valid && !fill_go && found;
  assign fire       = req_valid && req_ready;
  assign req_warp   = sel;
  assign req_addr   = pc_arr[sel] + PROG_BASE;
  assign req_size   = size_of(pc_arr[sel]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      miss_pend <= '0;
      fb_valid  <= 1'b0;
      fb_pc     <= '0;
      fb_size   <= '0;
      fb_warp   <= '0;
      last_warp <= '0;
    end else begin
      if (fb_valid && fb_take) fb_valid <= 1'b0;
      if (fill_go) begin
        miss_pend[fill_warp] <= 1'b0;
        fb_valid <= 1'b1;
        fb_pc    <= pc_arr[fill_warp];
        fb_size  <= size_of(pc_arr[fill_warp]);
        fb_warp  <= fill_warp;
      end else if (fire) begin
        last_warp <= sel;
        if (rsp_code == RSP_HIT) begin
          fb_valid <= 1'b1;
          fb_pc    <= pc_arr[sel];
          fb_size  <= size_of(pc_arr[sel]);
          fb_warp  <= sel;
        end else if (rsp_code == RSP_MISS) begin
          miss_pend[sel] <= 1'b1;
        end
      end
    end
  end

  // R7
  hit_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && rsp_code == RSP_HIT) |=>
      (fb_valid && fb_warp == $past(req_warp) && last_warp == $past(req_warp)));

  // R8
  miss_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && rsp_code == RSP_MISS) |=>
      (miss_pend[$past(req_warp)] && !fb_valid));

  // R12
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready && !fb_valid) |=> ($stable(last_warp) && $stable(miss_pend)));

  // R11
  fb_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fb_valid && !fb_take) |=> (fb_valid && $stable(fb_pc) && $stable(fb_warp) && $stable(fb_size)));

  // R10
  fill_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_valid && fill_ready) |-> !req_valid);

  // R6
  size_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (req_size != '0 && int'(req_size) <= FETCH_BYTES &&
                   int'(req_addr[OFF_W-1:0]) + int'(req_size) <= LINE_BYTES));

endmodule

// File: tb/warp_fetch_sel_bench.sv
`timescale 1ns/1ps
module warp_fetch_sel_bench;
  localparam int N = 8;
  localparam int LINE = 64;
  localparam int FB = 16;

  logic clk = 0, rst_n = 0;
  logic [N-1:0] warp_done = '0, ibuf_empty = '1;
  logic [N*32-1:0] warp_pc = '0;
  logic req_valid, req_ready = 0;
  logic [31:0] req_addr;
  logic [4:0] req_size;
  logic [2:0] req_warp;
  logic [1:0] rsp_code = 0;
  logic fill_valid = 0;
  logic [2:0] fill_warp = 0;
  logic fill_ready, fb_valid, fb_take = 0;
  logic [31:0] fb_pc;
  logic [4:0] fb_size;
  logic [2:0] fb_warp;
  logic [N-1:0] miss_pend;
  logic [2:0] last_warp;

  warp_fetch_sel u_warp_fetch_sel (.*);

  always #2 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;
  bit m_pend [N];
  bit m_fbv = 0;
  int m_fbpc = 0, m_fbsz = 0, m_fbw = 0, m_last = 0;

  function automatic int pc_of(int w);
    return int'(warp_pc[w*32 +: 32]);
  endfunction

  function automatic int exp_size(int pc);
    int off;
    off = pc & (LINE - 1);
    if (off > LINE - FB) return LINE - off;
    return FB;
  endfunction

  task automatic chk(string tag, longint got, longint exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic tick();
    int w, pend_vec;
    bit fill_go, rv;
    #1;
    w = -1;
    for (int k = 1; k <= N; k++) begin
      int c;
      c = (m_last + k) % N;
      if (w < 0 && !warp_done[c] && !m_pend[c] && ibuf_empty[c]) w = c;
    end
    fill_go = fill_valid && !m_fbv;
    rv = !m_fbv && !fill_go && (w >= 0);
    pend_vec = 0;
    for (int i = 0; i < N; i++) pend_vec |= int'(m_pend[i]) << i;
    chk("R4 req_valid", req_valid, rv);
    chk("R10 fill_ready", fill_ready, !m_fbv);
    if (rv) begin
      chk("R2/R3 req_warp", req_warp, w);
      chk("R5 req_addr", req_addr, (pc_of(w) + 32'hF000_0000) & 32'hFFFF_FFFF);
      chk("R6 req_size", req_size, exp_size(pc_of(w)));
    end
    chk("R11 fb_valid", fb_valid, m_fbv);
    if (m_fbv) begin
      chk("R7 fb_warp", fb_warp, m_fbw);
      chk("R7 fb_pc", fb_pc, m_fbpc & 32'hFFFF_FFFF);
      chk("R7 fb_size", fb_size, m_fbsz);
    end
    chk("R8 miss_pend", miss_pend, pend_vec);
    chk("R9/R12 last_warp", last_warp, m_last);
    if (m_fbv && fb_take) m_fbv = 0;
    if (fill_go) begin
      m_pend[fill_warp] = 0;
      m_fbv = 1; m_fbw = fill_warp; m_fbpc = pc_of(fill_warp);
      m_fbsz = exp_size(m_fbpc);
    end else if (rv && req_ready) begin
      m_last = w;
      if (rsp_code == 0) begin
        m_fbv = 1; m_fbw = w; m_fbpc = pc_of(w); m_fbsz = exp_size(m_fbpc);
      end else if (rsp_code == 1) m_pend[w] = 1;
    end
    @(negedge clk);
  endtask

  task automatic set_pc(int w, int pc);
    warp_pc[w*32 +: 32] = pc;
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1234_5678));
    for (int i = 0; i < N; i++) m_pend[i] = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 fb_valid", fb_valid, 0);
    chk("R1 miss_pend", miss_pend, 0);
    chk("R1 last_warp", last_warp, 0);
    rst_n = 1;
    @(negedge clk);
    // R1/R2: all eligible, first offer is warp 1; R12 stall
    for (int i = 0; i < N; i++) set_pc(i, 32'h1000 + i * 64);
    req_ready = 0; tick();
    // R9: only warp 7 eligible, offset 56 -> 8 bytes, reservation fail
    ibuf_empty = 8'h80; set_pc(7, 32'h1038); req_ready = 1; rsp_code = 2; tick();
    // R2 wrap to warp 0, offset 63 -> 1 byte, miss
    ibuf_empty = '1; set_pc(0, 32'h203F); rsp_code = 1; tick();
    // offset 48 -> 16 bytes, hit on warp 1
    set_pc(1, 32'h3030); rsp_code = 0; tick();
    // R4 buffer full, R10 fill ignored while full
    fill_valid = 1; fill_warp = 0; fb_take = 0; tick();
    fb_take = 1; tick();
    // R10 fill wins over eligible warps
    fb_take = 0; tick();
    fill_valid = 0; fb_take = 1; tick();
    // random phase
    for (int cyc = 0; cyc < 4000; cyc++) begin
      int cnt;
      for (int i = 0; i < N; i++) begin
        warp_done[i] = ($urandom % 8) == 0;
        ibuf_empty[i] = ($urandom % 8) != 0;
        set_pc(i, int'($urandom));
      end
      req_ready = ($urandom % 4) != 0;
      rsp_code = 2'($urandom % 3);
      fb_take = $urandom % 2;
      cnt = 0;
      for (int i = 0; i < N; i++) cnt += int'(m_pend[i]);
      fill_valid = 0;
      if (cnt > 0 && ($urandom % 3) == 0) begin
        int pick;
        pick = int'($urandom % N);
        while (!m_pend[pick]) pick = (pick + 1) % N;
        fill_valid = 1; fill_warp = 3'(pick);
      end
      tick();
    end
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule